// File: doc/BRIEF.md
# AGC Loop Filter Accumulator with Gain Limiter

The block is the integrating loop filter of an automatic gain control loop. On each output-sample strobe it moves a 16-bit accumulator by one programmable unsigned step. A one-bit decision from the level detector sets the direction: it steps up when the signal is below threshold and down when it is above. After every step the result is held inside a window set by two 8-bit limit words. A result that falls outside the window is replaced by the limit it crossed.

The accumulator's top byte is the gain control word. It is a pseudo floating point value: a 3-bit exponent in bits 7:5, a 4-bit mantissa in bits 4:1, and one finer bit in bit 0. The gain stage uses (1 + mantissa) × 2^exponent. The limit words use the same byte format. They are compared against the accumulator with zeros filling the eight lower bits. The step's LSB lines up with the accumulator LSB, so a step of 01h gives a very slow slew and FFh a fast one.

A hold input freezes the loop. A synchronous clear restarts the loop at the lower limit. A host can capture the gain word without disturbing the loop.

Top module: `agc_loop_filter`

## Requirements
- R1: After reset, acc_out is 0000h and host_word is 00h.
- R2: On a cycle with sample_stb high, agc_hold low, clear low and below_thr high, the accumulator becomes acc_out + loop_gain at the next clock edge. This holds when the sum stays inside the window.
- R3: On the same kind of cycle with below_thr low, the accumulator becomes acc_out − loop_gain. This holds when the difference stays inside the window.
- R4: With sample_stb low and clear low, the accumulator keeps its value, whatever the other inputs are.
- R5: If the exact step result is greater than {upper_lim, 8'h00}, the accumulator is loaded with {upper_lim, 8'h00}. A result past FFFFh counts as greater, with no wrap.
- R6: If the exact step result is less than {lower_lim, 8'h00}, the accumulator is loaded with {lower_lim, 8'h00}. A result below zero counts as less, with no wrap. The upper check takes priority.
- R7: With upper_lim equal to lower_lim, every step leaves the accumulator at exactly {limit, 8'h00}. This gives a fixed gain.
- R8: With agc_hold high and clear low, the accumulator keeps its value even when sample_stb is high.
- R9: clear loads {lower_lim, 8'h00} at the next edge. It takes priority over agc_hold and sample_stb.
- R10: gain_word always equals acc_out[15:8], with no added delay.
- R11: host_rd captures acc_out[15:8] into host_word at the next edge. Without host_rd, host_word holds its value. host_rd has no effect on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One step per cycle this is high |
| below_thr | input | 1 | Detector decision: 1 steps up, 0 steps down |
| loop_gain | input | 8 | Unsigned step size, LSB aligned to accumulator LSB |
| upper_lim | input | 8 | Upper limit, gain-word format |
| lower_lim | input | 8 | Lower limit, gain-word format |
| agc_hold | input | 1 | Freezes the accumulator |
| clear | input | 1 | Synchronous load of the lower limit |
| host_rd | input | 1 | Captures the gain word for the host |
| acc_out | output | 16 | Full accumulator |
| gain_word | output | 8 | Accumulator top byte, sent to the gain stage |
| host_word | output | 8 | Host snapshot of the gain word |

## Verification
Each step, clamp, clear or hold shows on acc_out one rising edge after the cycle that requested it. gain_word follows acc_out with no extra delay. host_word shows the captured byte one edge after host_rd. The bench drives every input just after a falling edge and compares all three outputs at the next falling edge. By then exactly one rising edge has passed, and its reference model has advanced by exactly one cycle.

// File: rtl/agc_loop_filter.sv
module agc_loop_filter #(
  parameter int ACC_W  = 16,
  parameter int WORD_W = 8,
  parameter int GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic              below_thr,
  input  logic [GAIN_W-1:0] loop_gain,
  input  logic [WORD_W-1:0] upper_lim,
  input  logic [WORD_W-1:0] lower_lim,
  input  logic              agc_hold,
  input  logic              clear,
  input  logic              host_rd,
  output logic [ACC_W-1:0]  acc_out,
  output logic [WORD_W-1:0] gain_word,
  output logic [WORD_W-1:0] host_word
);
  localparam int FRAC_W = ACC_W - WORD_W;
  localparam int EXT_W  = ACC_W + 2;

  logic [ACC_W-1:0]        acc_q, acc_nxt;
  logic [ACC_W-1:0]        hi_val, lo_val;
  logic signed [EXT_W-1:0] acc_ext, step_ext, sum_ext, hi_ext, lo_ext;

  assign hi_val   = {upper_lim, {FRAC_W{1'b0}}};
  assign lo_val   = {lower_lim, {FRAC_W{1'b0}}};
  assign acc_ext  = $signed({2'b00, acc_q});
  assign step_ext = $signed({{(EXT_W-GAIN_W){1'b0}}, loop_gain});
  assign hi_ext   = $signed({2'b00, hi_val});
  assign lo_ext   = $signed({2'b00, lo_val});
  assign sum_ext  = below_thr ? acc_ext + step_ext : acc_ext - step_ext;

  always_comb begin
    if (sum_ext > hi_ext)      acc_nxt = hi_val;
    else if (sum_ext < lo_ext) acc_nxt = lo_val;
    else                       acc_nxt = sum_ext[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        acc_q <= '0;
    else if (clear)                    acc_q <= lo_val;
    else if (sample_stb && !agc_hold)  acc_q <= acc_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_word <= '0;
    else if (host_rd) host_word <= acc_q[ACC_W-1 -: WORD_W];
  end

  assign acc_out   = acc_q;
  assign gain_word = acc_q[ACC_W-1 -: WORD_W];
endmodule

// File: rtl/agc_loop_filter_chk.sv
module agc_loop_filter_chk #(
  parameter int ACC_W  = 16,
  parameter int WORD_W = 8,
  parameter int GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic              below_thr,
  input logic [GAIN_W-1:0] loop_gain,
  input logic [WORD_W-1:0] upper_lim,
  input logic [WORD_W-1:0] lower_lim,
  input logic              agc_hold,
  input logic              clear,
  input logic              host_rd,
  input logic [ACC_W-1:0]  acc_out,
  input logic [WORD_W-1:0] gain_word,
  input logic [WORD_W-1:0] host_word
);
  localparam int FRAC_W = ACC_W - WORD_W;

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && !clear) |=> $stable(acc_out)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_hold && !clear) |=> $stable(acc_out)); // R8
  AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc_out == {$past(lower_lim), {FRAC_W{1'b0}}}); // R9
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !agc_hold && !clear && upper_lim >= lower_lim) |=>
      (acc_out <= {$past(upper_lim), {FRAC_W{1'b0}}} &&
       acc_out >= {$past(lower_lim), {FRAC_W{1'b0}}})); // R5
  AST_FIXED_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !agc_hold && !clear && upper_lim == lower_lim) |=>
      acc_out == {$past(lower_lim), {FRAC_W{1'b0}}}); // R7
  AST_HOST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_word == $past(gain_word)); // R11
  AST_HOST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_word)); // R11
endmodule

bind agc_loop_filter agc_loop_filter_chk #(.ACC_W(ACC_W), .WORD_W(WORD_W), .GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/agc_loop_filter_tb.sv
module agc_loop_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 0, below_thr = 0, agc_hold = 0, clear = 0, host_rd = 0;
  logic [7:0] loop_gain = 0, upper_lim = 0, lower_lim = 0;
  logic [15:0] acc_out;
  logic [7:0]  gain_word, host_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_acc = 0;
  logic [7:0]  m_host = 0;

  always #10 clk = ~clk;

  agc_loop_filter u_dut (.*);

  function automatic logic [15:0] ref_next(logic [15:0] a, output string tag);
    int s, hi, lo;
    hi = int'({upper_lim, 8'h00});
    lo = int'({lower_lim, 8'h00});
    if (clear) begin tag = "R9"; return {lower_lim, 8'h00}; end
    if (!sample_stb) begin tag = "R4"; return a; end
    if (agc_hold) begin tag = "R8"; return a; end
    s = below_thr ? int'(a) + int'(loop_gain) : int'(a) - int'(loop_gain);
    tag = (upper_lim == lower_lim) ? "R7" : below_thr ? "R2" : "R3";
    if (s > hi) begin if (upper_lim != lower_lim) tag = "R5"; return hi[15:0]; end
    if (s < lo) begin if (upper_lim != lower_lim) tag = "R6"; return lo[15:0]; end
    return s[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit stb, bit dir, logic [7:0] g, logic [7:0] up, logic [7:0] lo,
                     bit hold, bit clr, bit rd);
    string tag;
    sample_stb = stb; below_thr = dir; loop_gain = g; upper_lim = up;
    lower_lim = lo; agc_hold = hold; clear = clr; host_rd = rd;
    if (rd) m_host = m_acc[15:8];
    m_acc = ref_next(m_acc, tag);
    @(negedge clk);
    chk(tag, acc_out, m_acc);
    chk("R10", {8'h00, gain_word}, {8'h00, acc_out[15:8]});
    chk("R11", {8'h00, host_word}, {8'h00, m_host});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", acc_out, 16'h0000);
    chk("R1", {8'h00, host_word}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1, 1, 8'h10, 8'hFF, 8'h00, 0, 0, 0);
    cyc(1, 1, 8'h25, 8'hFF, 8'h00, 0, 0, 1);
    cyc(1, 0, 8'h05, 8'hFF, 8'h00, 0, 0, 0);
    cyc(0, 1, 8'hFF, 8'hFF, 8'h00, 0, 0, 0);
    cyc(1, 0, 8'hFF, 8'hFF, 8'h00, 0, 0, 0);
    cyc(1, 0, 8'h01, 8'hFF, 8'h00, 0, 0, 0);
    cyc(0, 0, 8'h00, 8'hFF, 8'hFF, 0, 1, 0);
    cyc(1, 1, 8'hFF, 8'hFF, 8'h00, 0, 0, 1);
    cyc(1, 1, 8'h80, 8'h40, 8'h10, 0, 0, 0);
    cyc(1, 1, 8'h20, 8'h40, 8'h40, 0, 0, 0);
    cyc(1, 0, 8'hFF, 8'h40, 8'h40, 0, 0, 0);
    cyc(1, 1, 8'h01, 8'h40, 8'h40, 0, 0, 0);
    cyc(1, 1, 8'h33, 8'hFF, 8'h00, 1, 0, 0);
    cyc(1, 1, 8'h33, 8'hFF, 8'h22, 1, 1, 0);
    cyc(1, 0, 8'h01, 8'hFF, 8'h22, 0, 0, 1);
    void'($urandom(32'h5eed_a9c1));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      if (a < b) begin a ^= b; b ^= a; a ^= b; end
      if ($urandom % 16 == 0) b = a;
      cyc(($urandom % 4) != 0, $urandom % 2, 8'($urandom), a, b,
          ($urandom % 8) == 0, ($urandom % 40) == 0, ($urandom % 6) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule